// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the pins of a parallel NOR flash and turns the host's bus writes into commands. A write is recognised when chip enable and write enable are both low while output enable is high. The address is taken in the first cycle of that window and the data in its last cycle. Each completed write is then matched against the multi-cycle unlock sequences.

Each recognised command leaves as a one-cycle pulse with its address and data: program, chip erase, sector erase, suspend, resume or soft reset. The block also tracks a mode, which is one of:

- normal read;
- identification (autoselect);
- query table (CFI);
- unlock bypass.

In the identification and query modes it returns the identification word for the offset on the address bus.

Writes that break a sequence return the decoder to read mode, or leave it in bypass mode, and no command is emitted. While the array engine reports a program in progress, every write is dropped.

Top module: `cmdseq_decoder`

## Requirements
- R1: After synchronous reset, `mode_o` is 0 (read), all six pulse outputs are low and `id_valid` is low.
- R2: A bus write is taken only while `ce_n` and `we_n` are both low and `oe_n` is high. Its address is the one present in the first cycle of that window. Its data is the value present in the last cycle before either strobe rises.
- R3: Standard program takes four writes:
  - in word mode: data AAh at key address 555h, then 55h at 2AAh, then A0h at 555h, then the program address and data;
  - in byte mode the keys are AAAh and 555h;
  - word mode compares 11 address bits and byte mode compares 12;
  - the fourth write gives `prog_pls` with that address and data on `cmd_addr` and `cmd_data`.
- R4: Outside bypass mode, a write whose low byte is F0h, at any address and at any sequence step except the program-data step, gives `soft_reset_pls` and returns `mode_o` to 0.
- R5: The unlock pair followed by 90h at the first key enters autoselect, `mode_o` = 1. There `id_data` returns:
  - the manufacturer code at offset 00h;
  - the device code at offset 01h;
  - at offset 02h, the `sect_prot` input in bit 0, where 1 means protected.

  The offset is address bits [7:0] in word mode and [8:1] in byte mode. In byte mode only the low byte is returned.
- R6: A single write of 98h at any address from read or autoselect enters query mode, `mode_o` = 2. In that mode:
  - offsets 10h, 11h and 12h return 51h, 52h and 59h;
  - offset 27h returns the log2 of the device size (15h by default).
- R7: Chip erase is the unlock pair, 80h at the first key, the unlock pair again, then 10h at the first key. It emits `chip_erase_pls`.
- R8: The same five-write prefix followed by 30h at any address emits `sect_erase_pls`, with that address on `cmd_addr`.
- R9: The unlock pair followed by 20h enters bypass, `mode_o` = 3. In bypass, A0h followed by an address/data write emits `prog_pls`. The sequence 90h then 00h, at any addresses, returns `mode_o` to 0.
- R10: In bypass mode any other write, including F0h, emits nothing and leaves `mode_o` at 3. A 90h followed by anything other than 00h keeps bypass.
- R11: From the idle step outside bypass, B0h emits `suspend_pls` and 30h emits `resume_pls`, at any address, with the mode unchanged.
- R12: A write that completes while `prog_busy` is high emits nothing and leaves the mode and sequence step unchanged.
- R13: A write that does not match the next expected cycle of a sequence emits nothing, sets `mode_o` to 0 and restarts the sequence.
- R14: At most one pulse output is high in any cycle, and no pulse lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 selects 8-bit bus keys and offsets |
| bus_addr | input | ADDR_W | Address bus, used for writes and identification reads |
| bus_dq | input | DATA_W | Write data from the bus |
| prog_busy | input | 1 | High while the array engine runs a program |
| sect_prot | input | 1 | Protection state of the addressed sector |
| mode_o | output | 2 | 0 read, 1 autoselect, 2 query, 3 bypass |
| prog_pls | output | 1 | Program command pulse |
| chip_erase_pls | output | 1 | Chip erase command pulse |
| sect_erase_pls | output | 1 | Sector erase command pulse |
| suspend_pls | output | 1 | Erase suspend pulse |
| resume_pls | output | 1 | Erase resume pulse |
| soft_reset_pls | output | 1 | Return-to-read command pulse |
| cmd_addr | output | ADDR_W | Address of the write that produced the pulse |
| cmd_data | output | DATA_W | Data of the write that produced the pulse |
| id_valid | output | 1 | High when `id_data` holds an identification or query word |
| id_data | output | DATA_W | Identification or query word for the current offset |

## Verification
The identification read path and the command decoder can act in the same cycle. This happens when an F0h write ends autoselect while the address bus still points at offset 00h. The bench makes that write at address 0 and samples in the cycle the reset pulse is high. It expects the manufacturer code to still be valid there and `id_valid` to be low one cycle later. A second overlap is a write completing while `prog_busy` is high just after a program has been armed. The bench expects no pulse from that write, and a following write with `prog_busy` low must still be taken as program data.

// File: rtl/cmdseq_pkg.sv
// Shared types and constants for the flash command sequence decoder.
// Assumes command bytes sit in the low eight data bits.
package cmdseq_pkg;

    typedef enum logic [1:0] {
        MODE_READ    = 2'd0,
        MODE_AUTOSEL = 2'd1,
        MODE_CFI     = 2'd2,
        MODE_BYPASS  = 2'd3
    } dec_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PDATA,
        ST_ER1,
        ST_ER2,
        ST_ER3,
        ST_BIDLE,
        ST_BPDATA,
        ST_BEXIT
    } seq_step_e;

    typedef struct packed {
        logic prog;
        logic chip_erase;
        logic sect_erase;
        logic suspend;
        logic resume;
        logic soft_reset;
    } cmd_pulse_t;

    localparam logic [7:0] CB_KEY_A   = 8'hAA;
    localparam logic [7:0] CB_KEY_B   = 8'h55;
    localparam logic [7:0] CB_PROG    = 8'hA0;
    localparam logic [7:0] CB_IDENT   = 8'h90;
    localparam logic [7:0] CB_ERASE   = 8'h80;
    localparam logic [7:0] CB_CHIP    = 8'h10;
    localparam logic [7:0] CB_SECT    = 8'h30;
    localparam logic [7:0] CB_BYPASS  = 8'h20;
    localparam logic [7:0] CB_QUERY   = 8'h98;
    localparam logic [7:0] CB_SUSPEND = 8'hB0;
    localparam logic [7:0] CB_RESUME  = 8'h30;
    localparam logic [7:0] CB_RESET   = 8'hF0;
    localparam logic [7:0] CB_BYPEXIT = 8'h00;

    // Key address check: second=0 picks the first key, second=1 the second.
    function automatic logic key_hit(input logic [11:0] a, input logic bm,
                                     input logic second);
        logic [11:0] exp_a;
        logic [11:0] mask;
        exp_a = bm ? (second ? 12'h555 : 12'hAAA)
                   : (second ? 12'h2AA : 12'h555);
        mask  = bm ? 12'hFFF : 12'h7FF;
        return (a & mask) == (exp_a & mask);
    endfunction

endpackage

// File: rtl/cmdseq_wr_capture.sv
// Turns the chip-enable / write-enable / output-enable pins into one strobe per
// bus write. The address is held from the first cycle of the write window and the
// data from its last cycle. Assumes the pins are already synchronous to clk.
module cmdseq_wr_capture #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_dq,
    output logic              wr_vld,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic win_now;
    logic win_q;

    // Write window: both strobes low, outputs disabled.
    assign win_now = !ce_n && !we_n && oe_n;

    // Track the window, capture address at its start and data during it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= 1'b0;
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            win_q  <= win_now;
            wr_vld <= win_q && !win_now;
            if (win_now && !win_q) begin
                wr_addr <= bus_addr;
            end
            if (win_now) begin
                wr_data <= bus_dq;
            end
        end
    end

endmodule

// File: rtl/cmdseq_fsm.sv
// Sequence tracker: walks the unlock cycles, keeps the mode and emits one-cycle
// command pulses with the address and data of the write that completed them.
// Assumes ADDR_W >= 12 and one write strobe at most every few cycles.
module cmdseq_fsm
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    input  logic              prog_busy,
    output dec_mode_e         mode_q,
    output cmd_pulse_t        pls_q,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    seq_step_e   step_q;
    seq_step_e   step_n;
    dec_mode_e   mode_n;
    cmd_pulse_t  pls_n;
    logic        take;
    logic        hit1;
    logic        hit2;
    logic [7:0]  cb;

    assign take = wr_vld && !prog_busy;
    assign cb   = wr_data[7:0];
    assign hit1 = key_hit(wr_addr[11:0], byte_mode, 1'b0);
    assign hit2 = key_hit(wr_addr[11:0], byte_mode, 1'b1);

    // Next step, next mode and pulse selection for an accepted write.
    always_comb begin
        step_n = step_q;
        mode_n = mode_q;
        pls_n  = '0;
        if (take) begin
            unique case (step_q)
                ST_BIDLE: begin
                    if (cb == CB_PROG) begin
                        step_n = ST_BPDATA;
                    end else if (cb == CB_IDENT) begin
                        step_n = ST_BEXIT;
                    end
                end
                ST_BPDATA: begin
                    pls_n.prog = 1'b1;
                    step_n     = ST_BIDLE;
                end
                ST_BEXIT: begin
                    if (cb == CB_BYPEXIT) begin
                        mode_n = MODE_READ;
                        step_n = ST_IDLE;
                    end else begin
                        step_n = ST_BIDLE;
                    end
                end
                ST_PDATA: begin
                    pls_n.prog = 1'b1;
                    mode_n     = MODE_READ;
                    step_n     = ST_IDLE;
                end
                default: begin
                    // Any write that matches nothing below falls back to read.
                    mode_n = MODE_READ;
                    step_n = ST_IDLE;
                    if (cb == CB_RESET) begin
                        pls_n.soft_reset = 1'b1;
                    end else begin
                        unique case (step_q)
                            ST_IDLE: begin
                                if (cb == CB_KEY_A && hit1) begin
                                    mode_n = mode_q;
                                    step_n = ST_KEY1;
                                end else if (cb == CB_SUSPEND) begin
                                    mode_n        = mode_q;
                                    pls_n.suspend = 1'b1;
                                end else if (cb == CB_RESUME) begin
                                    mode_n       = mode_q;
                                    pls_n.resume = 1'b1;
                                end else if (cb == CB_QUERY) begin
                                    mode_n = MODE_CFI;
                                end
                            end
                            ST_KEY1: begin
                                if (cb == CB_KEY_B && hit2) begin
                                    mode_n = mode_q;
                                    step_n = ST_KEY2;
                                end
                            end
                            ST_KEY2: begin
                                if (hit1) begin
                                    if (cb == CB_IDENT) begin
                                        mode_n = MODE_AUTOSEL;
                                    end else if (cb == CB_PROG) begin
                                        mode_n = mode_q;
                                        step_n = ST_PDATA;
                                    end else if (cb == CB_ERASE) begin
                                        mode_n = mode_q;
                                        step_n = ST_ER1;
                                    end else if (cb == CB_BYPASS) begin
                                        mode_n = MODE_BYPASS;
                                        step_n = ST_BIDLE;
                                    end
                                end
                            end
                            ST_ER1: begin
                                if (cb == CB_KEY_A && hit1) begin
                                    mode_n = mode_q;
                                    step_n = ST_ER2;
                                end
                            end
                            ST_ER2: begin
                                if (cb == CB_KEY_B && hit2) begin
                                    mode_n = mode_q;
                                    step_n = ST_ER3;
                                end
                            end
                            ST_ER3: begin
                                if (cb == CB_CHIP && hit1) begin
                                    pls_n.chip_erase = 1'b1;
                                end else if (cb == CB_SECT) begin
                                    pls_n.sect_erase = 1'b1;
                                end
                            end
                            default: begin
                                step_n = ST_IDLE;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // State, pulse and command payload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= ST_IDLE;
            mode_q   <= MODE_READ;
            pls_q    <= '0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            step_q <= step_n;
            mode_q <= mode_n;
            pls_q  <= pls_n;
            if (pls_n != '0) begin
                cmd_addr <= wr_addr;
                cmd_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/cmdseq_id_rom.sv
// Identification and query responses. Registers the word for the offset on the
// address bus, valid only in autoselect or query mode. Assumes reads are static
// for at least one cycle before sampling.
module cmdseq_id_rom
    import cmdseq_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          OFF_W     = 8,
    parameter logic [15:0] MFR_CODE  = 16'h0052,
    parameter logic [15:0] DEV_CODE  = 16'h22A7,
    parameter int          SIZE_LOG2 = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dec_mode_e         mode_q,
    input  logic              byte_mode,
    input  logic [OFF_W:0]    rd_addr,
    input  logic              sect_prot,
    output logic              id_valid,
    output logic [DATA_W-1:0] id_data
);

    logic [OFF_W-1:0] off;
    logic [15:0]      ident_w;
    logic [15:0]      query_w;
    logic [15:0]      pick_w;

    // Byte mode reads use one more low address bit per word.
    assign off = byte_mode ? rd_addr[OFF_W:1] : rd_addr[OFF_W-1:0];

    // Autoselect words.
    always_comb begin
        unique case (off)
            8'h00:   ident_w = MFR_CODE;
            8'h01:   ident_w = DEV_CODE;
            8'h02:   ident_w = {15'd0, sect_prot};
            default: ident_w = 16'h0000;
        endcase
    end

    // Query table words.
    always_comb begin
        unique case (off)
            8'h10:   query_w = 16'h0051;
            8'h11:   query_w = 16'h0052;
            8'h12:   query_w = 16'h0059;
            8'h13:   query_w = 16'h0002;
            8'h15:   query_w = 16'h0040;
            8'h27:   query_w = 16'(SIZE_LOG2);
            8'h2C:   query_w = 16'h0001;
            default: query_w = 16'h0000;
        endcase
    end

    assign pick_w = (mode_q == MODE_CFI) ? query_w : ident_w;

    // Register the selected word and its validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid <= 1'b0;
            id_data  <= '0;
        end else begin
            id_valid <= (mode_q == MODE_AUTOSEL) || (mode_q == MODE_CFI);
            id_data  <= byte_mode ? DATA_W'(pick_w[7:0]) : DATA_W'(pick_w);
        end
    end

endmodule

// File: rtl/cmdseq_decoder.sv
// Top of the flash command sequence decoder: bus write capture, sequence
// tracker and identification responses. Assumes all pins are synchronous to clk.
module cmdseq_decoder
    import cmdseq_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter int          DATA_W    = 16,
    parameter int          OFF_W     = 8,
    parameter logic [15:0] MFR_CODE  = 16'h0052,
    parameter logic [15:0] DEV_CODE  = 16'h22A7,
    parameter int          SIZE_LOG2 = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_dq,
    input  logic              prog_busy,
    input  logic              sect_prot,
    output logic [1:0]        mode_o,
    output logic              prog_pls,
    output logic              chip_erase_pls,
    output logic              sect_erase_pls,
    output logic              suspend_pls,
    output logic              resume_pls,
    output logic              soft_reset_pls,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              id_valid,
    output logic [DATA_W-1:0] id_data
);

    logic              wr_vld;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    dec_mode_e         mode_q;
    cmd_pulse_t        pls_q;

    cmdseq_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .bus_addr (bus_addr),
        .bus_dq   (bus_dq),
        .wr_vld   (wr_vld),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    cmdseq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_vld    (wr_vld),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .byte_mode (byte_mode),
        .prog_busy (prog_busy),
        .mode_q    (mode_q),
        .pls_q     (pls_q),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    cmdseq_id_rom #(
        .DATA_W    (DATA_W),
        .OFF_W     (OFF_W),
        .MFR_CODE  (MFR_CODE),
        .DEV_CODE  (DEV_CODE),
        .SIZE_LOG2 (SIZE_LOG2)
    ) u_id (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_q    (mode_q),
        .byte_mode (byte_mode),
        .rd_addr   (bus_addr[OFF_W:0]),
        .sect_prot (sect_prot),
        .id_valid  (id_valid),
        .id_data   (id_data)
    );

    assign mode_o         = mode_q;
    assign prog_pls       = pls_q.prog;
    assign chip_erase_pls = pls_q.chip_erase;
    assign sect_erase_pls = pls_q.sect_erase;
    assign suspend_pls    = pls_q.suspend;
    assign resume_pls     = pls_q.resume;
    assign soft_reset_pls = pls_q.soft_reset;

endmodule

// File: rtl/cmdseq_decoder_chk.sv
// Property checker for cmdseq_decoder, attached by bind.
module cmdseq_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_busy,
    input logic [1:0] mode_o,
    input logic       id_valid,
    input logic [5:0] pls
);

    // R14
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pls));

    // R14
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pls != 6'd0) |=> (pls == 6'd0));

    // R12
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |=> (pls == 6'd0));

    // R12
    busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |=> $stable(mode_o));

    // R9
    bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |=> (mode_o == 2'd3 || mode_o == 2'd0));

    // R5
    id_valid_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 || mode_o == 2'd2) |=> id_valid);

    // R5
    id_valid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 || mode_o == 2'd3) |=> !id_valid);

endmodule

bind cmdseq_decoder cmdseq_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_busy (prog_busy),
    .mode_o    (mode_o),
    .id_valid  (id_valid),
    .pls       ({prog_pls, chip_erase_pls, sect_erase_pls,
                 suspend_pls, resume_pls, soft_reset_pls})
);

// File: tb/cmdseq_decoder_tb.sv
module cmdseq_decoder_tb;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam logic [15:0] MFR = 16'h0052;
    localparam logic [15:0] DEV = 16'h22A7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic byte_mode = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_dq = '0;
    logic prog_busy = 1'b0;
    logic sect_prot = 1'b0;
    logic [1:0] mode_o;
    logic prog_pls, chip_erase_pls, sect_erase_pls, suspend_pls, resume_pls, soft_reset_pls;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic id_valid;
    logic [DATA_W-1:0] id_data;

    int n_chk = 0;
    int n_fail = 0;

    // Observations from the last write.
    logic [2:0]  obs_kind, obs_after;
    logic [1:0]  obs_mode;
    logic [ADDR_W-1:0] obs_addr;
    logic [DATA_W-1:0] obs_data, obs_idd;
    logic obs_idv, obs_idv_after;

    always #10 clk = ~clk;

    cmdseq_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .bus_addr(bus_addr), .bus_dq(bus_dq),
        .prog_busy(prog_busy), .sect_prot(sect_prot), .mode_o(mode_o),
        .prog_pls(prog_pls), .chip_erase_pls(chip_erase_pls),
        .sect_erase_pls(sect_erase_pls), .suspend_pls(suspend_pls),
        .resume_pls(resume_pls), .soft_reset_pls(soft_reset_pls),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .id_valid(id_valid), .id_data(id_data)
    );

    // Kind codes: 0 none, 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 reset.
    function automatic logic [2:0] kind_now();
        logic [2:0] k;
        k = 3'd0;
        if (prog_pls)       k = 3'd1;
        if (chip_erase_pls) k = 3'd2;
        if (sect_erase_pls) k = 3'd3;
        if (suspend_pls)    k = 3'd4;
        if (resume_pls)     k = 3'd5;
        if (soft_reset_pls) k = 3'd6;
        if ((prog_pls + chip_erase_pls + sect_erase_pls + suspend_pls
             + resume_pls + soft_reset_pls) > 1) k = 3'd7;
        return k;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // One bus write with a two-cycle window; samples pulses when they appear and one cycle later.
    task automatic wr_ext(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic oe_level);
        @(negedge clk);
        bus_addr = a; bus_dq = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_level;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        obs_kind = kind_now(); obs_mode = mode_o; obs_addr = cmd_addr; obs_data = cmd_data;
        obs_idv = id_valid; obs_idd = id_data;
        @(negedge clk);
        obs_after = kind_now(); obs_idv_after = id_valid;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_ext(a, d, 1'b1);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic v, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        v = id_valid; d = id_data;
    endtask

    localparam int NV = 49;
    // {address, data, expected kind, expected mode}
    localparam logic [40:0] TBL [0:NV-1] = '{
        {20'h00555, 16'h00AA, 3'd0, 2'd0}, {20'h002AA, 16'h0055, 3'd0, 2'd0},
        {20'h00555, 16'h00A0, 3'd0, 2'd0}, {20'h12345, 16'hBEEF, 3'd1, 2'd0},
        {20'h00555, 16'h00AA, 3'd0, 2'd0}, {20'h002AA, 16'h0055, 3'd0, 2'd0},
        {20'h00555, 16'h0080, 3'd0, 2'd0}, {20'h00555, 16'h00AA, 3'd0, 2'd0},
        {20'h002AA, 16'h0055, 3'd0, 2'd0}, {20'h00555, 16'h0010, 3'd2, 2'd0},
        {20'h00555, 16'h00AA, 3'd0, 2'd0}, {20'h002AA, 16'h0055, 3'd0, 2'd0},
        {20'h00555, 16'h0080, 3'd0, 2'd0}, {20'h00555, 16'h00AA, 3'd0, 2'd0},
        {20'h002AA, 16'h0055, 3'd0, 2'd0}, {20'h47000, 16'h0030, 3'd3, 2'd0},
        {20'h00000, 16'h00B0, 3'd4, 2'd0}, {20'h00123, 16'h0030, 3'd5, 2'd0},
        {20'h00555, 16'h00AA, 3'd0, 2'd0}, {20'h002AA, 16'h0055, 3'd0, 2'd0},
        {20'h00555, 16'h0090, 3'd0, 2'd1}, {20'h00000, 16'h00F0, 3'd6, 2'd0},
        {20'h00555, 16'h00AA, 3'd0, 2'd0}, {20'h002AB, 16'h0055, 3'd0, 2'd0},
        {20'h00555, 16'h00A0, 3'd0, 2'd0}, {20'h00100, 16'h1234, 3'd0, 2'd0},
        {20'h00555, 16'h00AA, 3'd0, 2'd0}, {20'h002AA, 16'h0055, 3'd0, 2'd0},
        {20'h00555, 16'h0020, 3'd0, 2'd3}, {20'h00000, 16'h00F0, 3'd0, 2'd3},
        {20'h00000, 16'h00A0, 3'd0, 2'd3}, {20'h00ABC, 16'h5A5A, 3'd1, 2'd3},
        {20'h00000, 16'h0090, 3'd0, 2'd3}, {20'h00000, 16'h0012, 3'd0, 2'd3},
        {20'h00000, 16'h0090, 3'd0, 2'd3}, {20'h00777, 16'h0000, 3'd0, 2'd0},
        {20'h00000, 16'h0098, 3'd0, 2'd2}, {20'h00000, 16'h00F0, 3'd6, 2'd0},
        {20'h00555, 16'h00AA, 3'd0, 2'd0}, {20'h002AA, 16'h0055, 3'd0, 2'd0},
        {20'h00555, 16'h0080, 3'd0, 2'd0}, {20'h00555, 16'h00AA, 3'd0, 2'd0},
        {20'h002AA, 16'h0055, 3'd0, 2'd0}, {20'h00555, 16'h0045, 3'd0, 2'd0},
        {20'h00555, 16'h00AA, 3'd0, 2'd0}, {20'h002AA, 16'h0055, 3'd0, 2'd0},
        {20'h00555, 16'h0090, 3'd0, 2'd1}, {20'h00000, 16'h0098, 3'd0, 2'd2},
        {20'h00000, 16'h00F0, 3'd6, 2'd0}
    };

    function automatic string vec_tag(input int i);
        if (i < 4)  return "R3 program";
        if (i < 10) return "R7 chip erase";
        if (i < 16) return "R8 sector erase";
        if (i < 18) return "R11 suspend/resume";
        if (i < 22) return "R4 reset from autoselect";
        if (i < 26) return "R13 mismatch";
        if (i < 30) return "R10 bypass ignores";
        if (i < 32) return "R9 bypass program";
        if (i < 36) return "R9 bypass exit";
        if (i < 38) return "R6 query from read";
        if (i < 44) return "R13 bad erase final";
        return "R6 query from autoselect";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic v;
        logic [DATA_W-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mode_o == 2'd0 && kind_now() == 3'd0 && !id_valid, "R1 reset state",
              {mode_o, kind_now(), id_valid}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [19:0] ea; logic [15:0] ed; logic [2:0] ek; logic [1:0] em;
            {ea, ed, ek, em} = TBL[i];
            wr(ea, ed);
            check(obs_kind == ek && obs_mode == em &&
                  (ek == 3'd0 || (obs_addr == ea && obs_data == ed)),
                  vec_tag(i), {obs_kind, obs_mode, obs_addr, obs_data}, {ek, em, ea, ed});
            if (ek != 3'd0)
                check(obs_after == 3'd0, "R14 single-cycle pulse", obs_after, 0);
        end

        // R5 autoselect reads
        wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h0090);
        rd(20'h3F000, v, d);
        check(v && d == MFR, "R5 manufacturer code", {v, d}, {1'b1, MFR});
        rd(20'h3F001, v, d);
        check(v && d == DEV, "R5 device code", {v, d}, {1'b1, DEV});
        sect_prot = 1'b1;
        rd(20'h51002, v, d);
        check(v && d == 16'h0001, "R5 protected sector", {v, d}, 17'h10001);
        sect_prot = 1'b0;
        rd(20'h51002, v, d);
        check(v && d == 16'h0000, "R5 unprotected sector", {v, d}, 17'h10000);
        // Same cycle: reset write ends autoselect while offset 00h is addressed.
        wr(20'h00000, 16'h00F0);
        check(obs_kind == 3'd6 && obs_idv && obs_idd == MFR, "R4 reset with id read",
              {obs_kind, obs_idv, obs_idd}, {3'd6, 1'b1, MFR});
        check(!obs_idv_after, "R5 id invalid after exit", obs_idv_after, 0);

        // R6 query table, word and byte mode
        wr(20'h00000, 16'h0098);
        rd(20'h00010, v, d);
        check(v && d == 16'h0051, "R6 query 10h", d, 16'h0051);
        rd(20'h00011, v, d);
        check(d == 16'h0052, "R6 query 11h", d, 16'h0052);
        rd(20'h00012, v, d);
        check(d == 16'h0059, "R6 query 12h", d, 16'h0059);
        rd(20'h00027, v, d);
        check(d == 16'h0015, "R6 size exponent", d, 16'h0015);
        byte_mode = 1'b1;
        rd(20'h00020, v, d);
        check(v && d == 16'h0051, "R6 byte-mode query", d, 16'h0051);
        wr(20'h00000, 16'h00F0);

        // R3 byte-mode keys
        wr(20'h00AAA, 16'h00AA); wr(20'h00555, 16'h0055); wr(20'h00AAA, 16'h00A0);
        wr(20'h01234, 16'h00C3);
        check(obs_kind == 3'd1 && obs_addr == 20'h01234 && obs_data == 16'h00C3,
              "R3 byte-mode program", {obs_kind, obs_addr, obs_data}, {3'd1, 20'h01234, 16'h00C3});
        wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
        wr(20'h04321, 16'h003C);
        check(obs_kind == 3'd0, "R3 word keys rejected in byte mode", obs_kind, 0);
        byte_mode = 1'b0;

        // R2 capture: address from window start, data from its end; oe_n low ignored.
        wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
        wr_ext(20'h00999, 16'h7777, 1'b0);
        check(obs_kind == 3'd0, "R2 write with oe_n low ignored", obs_kind, 0);
        @(negedge clk);
        bus_addr = 20'h0AAAA; bus_dq = 16'h1111; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        bus_addr = 20'h0BBBB; bus_dq = 16'h2222;
        @(negedge clk);
        bus_dq = 16'h3333;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(kind_now() == 3'd1 && cmd_addr == 20'h0AAAA && cmd_data == 16'h3333,
              "R2 capture edges", {kind_now(), cmd_addr, cmd_data}, {3'd1, 20'h0AAAA, 16'h3333});

        // R12 busy drops writes and keeps the armed step
        wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
        prog_busy = 1'b1;
        wr(20'h00222, 16'h1111);
        check(obs_kind == 3'd0 && obs_mode == 2'd0, "R12 busy write dropped",
              {obs_kind, obs_mode}, 0);
        prog_busy = 1'b0;
        wr(20'h00333, 16'h2222);
        check(obs_kind == 3'd1 && obs_addr == 20'h00333 && obs_data == 16'h2222,
              "R12 step kept across busy", {obs_kind, obs_addr, obs_data}, {3'd1, 20'h00333, 16'h2222});

        // R1 reset mid-sequence clears the mode
        wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h0020);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(mode_o == 2'd0 && !id_valid, "R1 reset leaves bypass", {mode_o, id_valid}, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule